// File: doc/BRIEF.md
# Count/Compare Timer with Sticky Interrupt

This block keeps a free-running counter and a compare register of the same width, 32 bits by default. On every clock where the tick strobe is high and counting is not halted, the counter steps by one. The step uses nominal 100 MHz ticks, and the count wraps modulo 2^W. If the value just stepped into equals the compare register, a level interrupt request is raised. That request stays up until software writes the compare register. No other action clears it.

Software can load the counter, load the compare register, and read the live count. A halt input freezes the counter and suppresses new matches.

A 3-bit release-select input decides whether a pending-status flag is kept beside the interrupt line. Only the encoding 3'b001 enables it. Every other value forces the flag to 0.

All ports are plain control, status and register-access pins. There is no streaming data path, so no valid/ready handshake is used, and a write strobe is accepted in the cycle it is high.

Top module: `cc_timer`

## Requirements
- R1: After reset, `count_o` reads 1, `irq_o` is 0 and `pend_o` is 0. The compare register resets to 0, so a counter stepped from 0xFFFFFFFF to 0 raises `irq_o` with no prior compare write.
- R2: On a clock edge where `tick_i`=1, `halt_i`=0 and `cnt_wr_i`=0, `count_o` becomes its previous value plus 1 modulo 2^W. With `tick_i`=0, the count holds.
- R3: While `halt_i`=1 (and `cnt_wr_i`=0), `count_o` holds its value and no new interrupt is raised, even when `tick_i`=1 and the next value would equal compare.
- R4: When a step makes the count equal to the compare register, `irq_o` is 1 from the same edge at which `count_o` shows the matching value.
- R5: Once set, `irq_o` stays 1 while counting continues past the match, until a compare write.
- R6: A compare write loads `cmp_wdata_i` and drives `irq_o` to 0 at the next edge. The write also wins over a match that occurs on that same edge.
- R7: A count write loads `cnt_wdata_i` into the counter, takes precedence over a tick in the same cycle, and leaves compare unchanged. Loading a value equal to compare does not raise `irq_o`; the next match comes only after the counter steps onto compare again.
- R8: With `rel_sel_i`=3'b001, `pend_o` is set together with `irq_o` on a match and cleared by a compare write. With any other `rel_sel_i` value, `pend_o` is 0 after the next edge, while `irq_o` still follows R4 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable strobe, one step per high cycle |
| halt_i | input | 1 | Freeze counting and matching |
| cnt_wr_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | W | Value to load into the counter |
| cmp_wr_i | input | 1 | Compare register write strobe (also acknowledges the interrupt) |
| cmp_wdata_i | input | W | Value to load into compare |
| rel_sel_i | input | 3 | Release select; 3'b001 keeps the pending flag |
| count_o | output | W | Live counter value |
| irq_o | output | 1 | Level interrupt request |
| pend_o | output | 1 | Timer-pending status flag |

## Verification
A corrupted counter shows on `count_o` at the very next sample, because the count is visible directly. A wrong compare register is hidden until the counter reaches the affected value, and then shows as a missing or misplaced rise of `irq_o`. The bench therefore places matches deliberately, including at wraparound, at halt, and on the same edge as a compare write. A stuck or misdecoded interrupt or pending flag shows within one edge of the match or acknowledge that should move it. Any of these faults is caught by the per-clock comparison against the reference model.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  // Release-select encoding that keeps the pending status flag
  localparam logic [2:0] REL_KEEP_PEND = 3'b001;

  // Per-cycle counter operation chosen by the top-level decode
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/cc_count_unit.sv
module cc_count_unit
  import cc_timer_pkg::*;
#(
  parameter int unsigned W         = 32,
  parameter logic [W-1:0] RST_VAL  = W'(1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_op_e      op_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] step_val_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign step_val_o = cnt_q + W'(1);

  always_comb begin
    unique case (op_i)
      CNT_STEP: cnt_d = step_val_o;
      CNT_LOAD: cnt_d = load_val_i;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RST_VAL;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_STEP) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_HOLD) |=> $stable(cnt_q));

  // R7
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_LOAD) |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/cc_match_unit.sv
module cc_match_unit
  import cc_timer_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cnt_op_e      op_i,
  input  logic [W-1:0] step_val_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_wdata_i,
  output logic         match_o
);

  logic [W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_wr_i) cmp_q <= cmp_wdata_i;
  end

  // Only a step onto the compare value counts as a match
  assign match_o = (op_i == CNT_STEP) && (step_val_i == cmp_q);

  // R6
  cmp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_wr_i |=> (cmp_q == $past(cmp_wdata_i)));

  // R7
  cmp_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_wr_i |=> $stable(cmp_q));

endmodule

// File: rtl/cc_irq_unit.sv
module cc_irq_unit
  import cc_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_i,
  input  logic       ack_i,
  input  logic [2:0] rel_sel_i,
  output logic       irq_o,
  output logic       pend_o
);

  logic irq_q, pend_q;
  logic keep_pend;

  assign keep_pend = (rel_sel_i == REL_KEEP_PEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ack_i)        irq_q <= 1'b0;
      else if (match_i) irq_q <= 1'b1;

      if (!keep_pend)   pend_q <= 1'b0;
      else if (ack_i)   pend_q <= 1'b0;
      else if (match_i) pend_q <= 1'b1;
    end
  end

  assign irq_o  = irq_q;
  assign pend_o = pend_q;

  // R4
  match_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && !ack_i) |=> irq_q);

  // R5
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ack_i) |=> irq_q);

  // R6
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_q);

  // R8
  pend_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !keep_pend |=> !pend_q);

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         halt_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic [2:0]   rel_sel_i,
  output logic [W-1:0] count_o,
  output logic         irq_o,
  output logic         pend_o
);

  localparam logic [W-1:0] CNT_RST = W'(1);

  cnt_op_e      op;
  logic [W-1:0] step_val;
  logic         match;

  // A count write outranks a tick; halt blocks only stepping
  always_comb begin
    if (cnt_wr_i)             op = CNT_LOAD;
    else if (tick_i && !halt_i) op = CNT_STEP;
    else                      op = CNT_HOLD;
  end

  cc_count_unit #(.W(W), .RST_VAL(CNT_RST)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .load_val_i (cnt_wdata_i),
    .cnt_o      (count_o),
    .step_val_o (step_val)
  );

  cc_match_unit #(.W(W)) u_match (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .step_val_i  (step_val),
    .cmp_wr_i    (cmp_wr_i),
    .cmp_wdata_i (cmp_wdata_i),
    .match_o     (match)
  );

  cc_irq_unit u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .match_i   (match),
    .ack_i     (cmp_wr_i),
    .rel_sel_i (rel_sel_i),
    .irq_o     (irq_o),
    .pend_o    (pend_o)
  );

  // R3
  halt_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && !cnt_wr_i && !cmp_wr_i && !irq_o) |=> !irq_o);

  // R7
  load_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr_i && !cmp_wr_i && !irq_o) |=> !irq_o);

endmodule

// File: tb/tb_cc_timer.sv
module tb_cc_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 0, halt = 0, cw = 0, mw = 0;
  logic [31:0] cwd = '0, mwd = '0;
  logic [2:0]  rel = 3'b001;
  logic [31:0] count;
  logic        irq, pend;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // behavioural reference state
  bit [31:0] m_cnt, m_cmp;
  bit        m_irq, m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .halt_i(halt),
    .cnt_wr_i(cw), .cnt_wdata_i(cwd), .cmp_wr_i(mw), .cmp_wdata_i(mwd),
    .rel_sel_i(rel), .count_o(count), .irq_o(irq), .pend_o(pend)
  );

  always @(posedge clk) begin
    bit hit;
    hit = 1'b0;
    if (!rst_n) begin
      m_cnt = 32'd1; m_cmp = 32'd0; m_irq = 1'b0; m_pend = 1'b0;
    end else begin
      if (cw) m_cnt = cwd;
      else if (tick && !halt) begin
        m_cnt = m_cnt + 32'd1;
        hit = (m_cnt == m_cmp);
      end
      if (mw) begin
        m_cmp = mwd; m_irq = 1'b0; m_pend = 1'b0;
      end else if (hit) begin
        m_irq = 1'b1; m_pend = 1'b1;
      end
      if (rel != 3'b001) m_pend = 1'b0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "model count", count, m_cnt);
      chk("R4", "model irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R8", "model pend", {31'd0, pend}, {31'd0, m_pend});
    end
  end

  task automatic drive(input logic t, input logic h, input logic c_wr,
                       input logic [31:0] c_d, input logic m_wr,
                       input logic [31:0] m_d);
    tick = t; halt = h; cw = c_wr; cwd = c_d; mw = m_wr; mwd = m_d;
    @(negedge clk);
    tick = 0; halt = 0; cw = 0; mw = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "reset count", count, 32'd1);
    chk("R1", "reset irq", {31'd0, irq}, 32'd0);
    chk("R1", "reset pend", {31'd0, pend}, 32'd0);

    // R2 plain stepping and idle hold
    for (int i = 0; i < 5; i++) drive(1, 0, 0, 0, 0, 0);
    chk("R2", "after 5 ticks", count, 32'd6);
    drive(0, 0, 0, 0, 0, 0);
    chk("R2", "no tick holds", count, 32'd6);

    // R3 halt freezes
    for (int i = 0; i < 3; i++) drive(1, 1, 0, 0, 0, 0);
    chk("R3", "halted count", count, 32'd6);

    // R4/R5/R8 match with pending kept
    drive(0, 0, 0, 0, 1, 32'd10);
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, 0, 0);
    chk("R4", "before match irq", {31'd0, irq}, 32'd0);
    drive(1, 0, 0, 0, 0, 0);
    chk("R4", "match count", count, 32'd10);
    chk("R4", "match irq", {31'd0, irq}, 32'd1);
    chk("R8", "match pend", {31'd0, pend}, 32'd1);
    for (int i = 0; i < 4; i++) drive(1, 0, 0, 0, 0, 0);
    chk("R5", "irq sticky", {31'd0, irq}, 32'd1);

    // R6 compare write acknowledges
    drive(1, 0, 0, 0, 1, 32'd3);
    chk("R6", "ack irq", {31'd0, irq}, 32'd0);
    chk("R8", "ack pend", {31'd0, pend}, 32'd0);

    // R7 loading a value equal to compare does not fire
    drive(0, 0, 1, 32'd3, 0, 0);
    chk("R7", "loaded count", count, 32'd3);
    chk("R7", "load equal no irq", {31'd0, irq}, 32'd0);
    drive(1, 0, 0, 0, 0, 0);
    chk("R7", "step past no irq", {31'd0, irq}, 32'd0);
    // R7 load beats tick; compare kept: step 4->... reach 5? compare is 3
    drive(1, 0, 1, 32'd1, 0, 0);
    chk("R7", "load wins over tick", count, 32'd1);
    drive(1, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0);
    chk("R7", "compare kept after load", {31'd0, irq}, 32'd1);
    drive(0, 0, 0, 0, 1, 32'd0);

    // R2 wrap and R4 match at zero
    drive(0, 0, 1, 32'hFFFF_FFFE, 0, 0);
    drive(1, 0, 0, 0, 0, 0);
    chk("R2", "near wrap", count, 32'hFFFF_FFFF);
    drive(1, 0, 0, 0, 0, 0);
    chk("R2", "wrapped", count, 32'd0);
    chk("R4", "match at zero", {31'd0, irq}, 32'd1);

    // R3 halt blocks a would-be match
    drive(0, 0, 1, 32'd4, 1, 32'd5);
    drive(1, 1, 0, 0, 0, 0);
    chk("R3", "halt count", count, 32'd4);
    chk("R3", "halt no irq", {31'd0, irq}, 32'd0);

    // R6 compare write beats a same-edge match
    drive(1, 0, 0, 0, 1, 32'd5);
    chk("R6", "same-edge count", count, 32'd5);
    chk("R6", "same-edge irq", {31'd0, irq}, 32'd0);

    // R8 other release encoding keeps pend at 0
    rel = 3'b010;
    drive(0, 0, 1, 32'd4, 0, 0);
    drive(1, 0, 0, 0, 0, 0);
    chk("R8", "irq with rel=2", {31'd0, irq}, 32'd1);
    chk("R8", "pend with rel=2", {31'd0, pend}, 32'd0);
    rel = 3'b001;
    drive(0, 0, 0, 0, 1, 32'd100);
    chk("R8", "pend after ack", {31'd0, pend}, 32'd0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule